// File: doc/BRIEF.md
# Time Slot Interchanger

This block reorders the samples of a framed, slot-synchronous stream. Each input sample arrives in a time slot of a frame. Its slot number is the only thing that says where it goes, because samples carry no header. The block stores every incoming frame in sample memory in arrival order. During the following frame it reads that frame back in the order given by a connection table. The sample placed in output slot `k` is the one that arrived in input slot `map[k]`. A demultiplexer downstream then delivers it to the link that owns slot `k`. Several output slots may name the same input slot, which gives multicast.

The sample memory has two banks. One bank fills with the current frame while the other is read out, and the two swap at every frame start. Connection table writes go to a shadow copy. The shadow copy is loaded into the working table at the first slot of the next frame, so every output frame is built from one consistent map. Output slots with no connection carry an idle code with the valid flag low. Cycles with `in_valid` low are gaps. A gap does not advance the slot position and produces no output.

Top module: `tsi_unit`

## Requirements
- R1: After a synchronous reset, `out_valid` and `out_frame_start` are 0, `out_sample` equals `IDLE_CODE`, and every output slot is unconnected.
- R2: An input slot accepted with `in_valid` high produces its output slot two clock cycles later, and the content is taken from the previous complete frame. The output therefore trails the input by one frame.
- R3: Output slot `k` carries the sample that arrived in input slot `map[k]` of the previous frame (slots are numbered from 0, and slot 0 is the cycle with `in_frame_start` high). With 4 slots and map {2,0,3,1}, an input frame a,b,c,d is emitted as c,a,d,b.
- R4: Two or more output slots mapped to the same input slot each carry that same sample in the same frame (multicast).
- R5: An output slot whose map entry is unconnected gives `out_valid`=0 and `out_sample`=`IDLE_CODE`.
- R6: A map write (`map_wr`=1 with `map_slot`, `map_src` and `map_conn`) changes no output until the next `in_frame_start` slot. From that slot on, the whole frame uses the new map.
- R7: During the first frame after reset there is no previous frame, so every slot gives `out_valid`=0 and `IDLE_CODE`.
- R8: `out_frame_start` is 1 exactly on the output slot produced from an input cycle with `in_valid` and `in_frame_start` both high, whether or not that slot is connected.
- R9: A cycle with `in_valid`=0 gives `out_valid`=0, `out_frame_start`=0 and `IDLE_CODE` two cycles later, and does not advance the slot position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Current cycle carries an input slot |
| in_frame_start | input | 1 | Current input slot is slot 0 of a frame |
| in_sample | input | SAMPLE_W | Input sample |
| map_wr | input | 1 | Write one shadow map entry |
| map_slot | input | SLOT_W | Output slot being mapped |
| map_src | input | SLOT_W | Input slot that feeds it |
| map_conn | input | 1 | 1 = connected, 0 = unconnected |
| out_valid | output | 1 | Output slot carries a connected sample |
| out_frame_start | output | 1 | Output slot is slot 0 of a frame |
| out_sample | output | SAMPLE_W | Output sample or idle code |

## Verification
The bench targets four failure modes:
- **Map written mid-frame.** A write lands between two slots of the same frame. A design without staging would switch the remaining slots of that frame to the new map.
- **Multicast plus a disconnected slot.** Two output slots share one source in the same frame that also leaves a slot unconnected. A design that leaks stale memory data, or holds `out_valid` high, would show a wrong sample or a wrong flag there.
- **First frame after reset.** A design that forgets the missing previous frame would emit unwritten memory as valid.
- **Gaps inside a frame.** Gaps are inserted mid-frame. A design that advanced the slot count on them would shift every later slot by one position.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
  typedef struct packed {
    logic live;
    logic conn;
    logic sof;
  } tsi_ctl_t;
endpackage

// File: rtl/tsi_slot_ctrl.sv
module tsi_slot_ctrl #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_frame_start,
  output logic [SW-1:0] cur_slot,
  output logic          wr_bank,
  output logic          prev_ok,
  output logic          commit
);
  logic [SW-1:0] cnt_q;
  logic          bank_q;
  logic          seen_q;
  logic          prev_q;

  assign commit   = in_valid & in_frame_start;
  assign cur_slot = in_frame_start ? '0 : cnt_q;
  assign wr_bank  = commit ? ~bank_q : bank_q;
  assign prev_ok  = commit ? seen_q : prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      bank_q <= 1'b0;
      seen_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      if (in_valid)
        cnt_q <= (cur_slot == SW'(SLOTS - 1)) ? '0 : cur_slot + 1'b1;
      if (commit) begin
        bank_q <= ~bank_q;
        seen_q <= 1'b1;
        prev_q <= seen_q;
      end
    end
  end

  // R2: banks swap only at a frame start
  a_r2_bank_swap: assert property (@(posedge clk) disable iff (rst)
    (bank_q != $past(bank_q)) |-> $past(commit));
  // R7: no previous frame can be usable before a first frame was seen
  a_r7_no_prev_early: assert property (@(posedge clk) disable iff (rst)
    !seen_q |-> !prev_q);
endmodule

// File: rtl/tsi_map.sv
module tsi_map #(
  parameter int SLOTS = 32,
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [SW-1:0] wr_slot,
  input  logic [SW-1:0] wr_src,
  input  logic          wr_conn,
  input  logic          commit,
  input  logic [SW-1:0] look_slot,
  output logic          look_conn,
  output logic [SW-1:0] look_src
);
  logic [SLOTS-1:0]         sh_conn, act_conn;
  logic [SLOTS-1:0][SW-1:0] sh_src, act_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_conn  <= '0;
      sh_src   <= '0;
      act_conn <= '0;
      act_src  <= '0;
    end else begin
      if (commit) begin
        act_conn <= sh_conn;
        act_src  <= sh_src;
      end
      if (wr) begin
        sh_conn[wr_slot] <= wr_conn;
        sh_src[wr_slot]  <= wr_src;
      end
    end
  end

  // the frame that starts now already reads through the staged entry
  assign look_conn = commit ? sh_conn[look_slot] : act_conn[look_slot];
  assign look_src  = commit ? sh_src[look_slot]  : act_src[look_slot];

  // R6: the working table moves only at a frame start
  a_r6_active_hold: assert property (@(posedge clk) disable iff (rst)
    !commit |=> ($stable(act_conn) && $stable(act_src)));
endmodule

// File: rtl/tsi_store.sv
module tsi_store #(
  parameter int SLOTS    = 32,
  parameter int SAMPLE_W = 8,
  localparam int AW      = $clog2(SLOTS) + 1,
  localparam int DEPTH   = 2 * SLOTS
) (
  input  logic                clk,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic [SAMPLE_W-1:0] wdata,
  input  logic [AW-1:0]       raddr,
  output logic [SAMPLE_W-1:0] rdata
);
  logic [SAMPLE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/tsi_unit.sv
module tsi_unit #(
  parameter int SLOTS                = 32,
  parameter int SAMPLE_W             = 8,
  parameter logic [SAMPLE_W-1:0] IDLE_CODE = '1,
  localparam int SLOT_W              = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                in_valid,
  input  logic                in_frame_start,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                map_wr,
  input  logic [SLOT_W-1:0]   map_slot,
  input  logic [SLOT_W-1:0]   map_src,
  input  logic                map_conn,
  output logic                out_valid,
  output logic                out_frame_start,
  output logic [SAMPLE_W-1:0] out_sample
);
  import tsi_pkg::*;

  logic [SLOT_W-1:0]   cur_slot, src;
  logic                wr_bank, prev_ok, commit, conn;
  logic [SAMPLE_W-1:0] rd_q;
  tsi_ctl_t            ctl_q;

  tsi_slot_ctrl #(.SLOTS(SLOTS)) u_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_frame_start(in_frame_start),
    .cur_slot(cur_slot), .wr_bank(wr_bank), .prev_ok(prev_ok), .commit(commit));

  tsi_map #(.SLOTS(SLOTS)) u_map (
    .clk(clk), .rst(rst), .wr(map_wr), .wr_slot(map_slot), .wr_src(map_src),
    .wr_conn(map_conn), .commit(commit), .look_slot(cur_slot),
    .look_conn(conn), .look_src(src));

  tsi_store #(.SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)) u_store (
    .clk(clk), .we(in_valid), .waddr({wr_bank, cur_slot}), .wdata(in_sample),
    .raddr({~wr_bank, src}), .rdata(rd_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q           <= '0;
      out_valid       <= 1'b0;
      out_frame_start <= 1'b0;
      out_sample      <= IDLE_CODE;
    end else begin
      ctl_q.live      <= in_valid;
      ctl_q.conn      <= in_valid & prev_ok & conn;
      ctl_q.sof       <= commit;
      out_valid       <= ctl_q.conn;
      out_frame_start <= ctl_q.sof;
      out_sample      <= ctl_q.conn ? rd_q : IDLE_CODE;
    end
  end

  // R5: an invalid slot always shows the idle code
  a_r5_idle_code: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_sample == IDLE_CODE));
  // R9: no output without an input slot two cycles earlier
  a_r9_gap_silent: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid, 2));
  // R8: output frame marker follows the input marker
  a_r8_sof_follow: assert property (@(posedge clk) disable iff (rst)
    out_frame_start |-> ($past(in_frame_start, 2) && $past(in_valid, 2)));
endmodule

// File: tb/sim_tsi_unit.sv
module sim_tsi_unit;
  localparam int S = 4;
  localparam int W = 8;
  localparam logic [W-1:0] IDLE = 8'hFF;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_frame_start, map_wr, map_conn;
  logic [W-1:0] in_sample, out_sample;
  logic [1:0] map_slot, map_src;
  logic out_valid, out_frame_start;

  always #5 clk = ~clk;

  tsi_unit #(.SLOTS(S), .SAMPLE_W(W), .IDLE_CODE(IDLE)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_frame_start(in_frame_start),
    .in_sample(in_sample), .map_wr(map_wr), .map_slot(map_slot), .map_src(map_src),
    .map_conn(map_conn), .out_valid(out_valid), .out_frame_start(out_frame_start),
    .out_sample(out_sample));

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  logic [W-1:0] m_cur [S];
  logic [W-1:0] m_prev [S];
  logic       sh_c [S], ac_c [S];
  logic [1:0] sh_s [S], ac_s [S];
  bit m_seen = 0, m_prevok = 0;
  int m_slot = 0;

  // two-deep expectation pipe
  bit e1_live = 0, e2_live = 0;
  logic e1_v, e2_v, e1_f, e2_f;
  logic [W-1:0] e1_d, e2_d;
  string e1_r, e2_r;

  task automatic check(string req, logic v, logic f, logic [W-1:0] d);
    checks++;
    if (out_valid !== v || out_frame_start !== f || out_sample !== d) begin
      errors++;
      $display("FAIL %s: got v=%0b sof=%0b d=%02h, expected v=%0b sof=%0b d=%02h",
               req, out_valid, out_frame_start, out_sample, v, f, d);
    end
  endtask

  task automatic step(bit iv, bit ifs, logic [W-1:0] d, bit mw, int ms, int msrc,
                      bit mc, string req);
    logic ev, ef;
    logic [W-1:0] ed;
    @(negedge clk);
    if (e2_live) check(e2_r, e2_v, e2_f, e2_d);
    e2_live = e1_live; e2_v = e1_v; e2_f = e1_f; e2_d = e1_d; e2_r = e1_r;
    if (iv && ifs) begin
      for (int i = 0; i < S; i++) begin
        ac_c[i] = sh_c[i]; ac_s[i] = sh_s[i]; m_prev[i] = m_cur[i];
      end
      m_prevok = m_seen; m_seen = 1; m_slot = 0;
    end
    ev = iv && m_prevok && ac_c[m_slot];
    ed = ev ? m_prev[ac_s[m_slot]] : IDLE;
    ef = iv && ifs;
    if (iv) begin
      m_cur[m_slot] = d;
      m_slot = (m_slot + 1) % S;
    end
    if (mw) begin
      sh_c[ms] = mc; sh_s[ms] = 2'(msrc);
    end
    e1_live = 1; e1_v = ev; e1_f = ef; e1_d = ed; e1_r = req;
    in_valid = iv; in_frame_start = ifs; in_sample = d;
    map_wr = mw; map_slot = 2'(ms); map_src = 2'(msrc); map_conn = mc;
  endtask

  task automatic idle(string req);
    step(0, 0, 8'h00, 0, 0, 0, 0, req);
  endtask

  task automatic wmap(int ms, int msrc, bit mc, string req);
    step(0, 0, 8'h00, 1, ms, msrc, mc, req);
  endtask

  task automatic frame(logic [W-1:0] base, string r0, string rest);
    for (int k = 0; k < S; k++)
      step(1, k == 0, base + W'(k), 0, 0, 0, 0, (k == 0) ? r0 : rest);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1", 1'b0, 1'b0, IDLE);
    @(negedge clk);
    check("R1", 1'b0, 1'b0, IDLE);
  endtask

  // R3 map {2,0,3,1}; R7 first frame silent; R2/R8 next frame
  task automatic t_permute;
    wmap(0, 2, 1, "R1");
    wmap(1, 0, 1, "R9");
    wmap(2, 3, 1, "R9");
    wmap(3, 1, 1, "R9");
    frame(8'h11, "R7", "R7");
    frame(8'h21, "R8", "R3");
    idle("R2");
  endtask

  // R6 mid-frame writes; R9 gaps; then R4 multicast and R5 disconnect
  task automatic t_stage_multicast;
    step(1, 1, 8'h31, 0, 0, 0, 0, "R2");
    step(1, 0, 8'h32, 0, 0, 0, 0, "R3");
    wmap(0, 2, 1, "R9");
    wmap(1, 2, 1, "R9");
    wmap(3, 1, 0, "R9");
    step(1, 0, 8'h33, 0, 0, 0, 0, "R6");
    step(1, 0, 8'h34, 0, 0, 0, 0, "R6");
    frame(8'h41, "R4", "R4");
    frame(8'h51, "R8", "R5");
    idle("R9");
    idle("R9");
    idle("R9");
  endtask

  initial begin
    for (int i = 0; i < S; i++) begin
      sh_c[i] = 0; ac_c[i] = 0; sh_s[i] = 0; ac_s[i] = 0;
      m_cur[i] = IDLE; m_prev[i] = IDLE;
    end
    rst = 1; in_valid = 0; in_frame_start = 0; in_sample = 0;
    map_wr = 0; map_slot = 0; map_src = 0; map_conn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset();
    t_permute();
    t_stage_multicast();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule